// File: doc/BRIEF.md
# Transmit Carrier-Loss Monitor

This block watches each outgoing frame and decides whether the carrier that should come back from the medium was present for the whole transmission. A frame is delimited by a plain `tx_active` level. While it is high, the block follows the carrier-sense input from the chosen port and the link-fail state. When it falls, the block publishes a transmit status byte in which one bit reports a loss of carrier, and it marks that byte valid for one cycle.

The rule that applies depends on the port and on the loopback mode. Both are captured in the first cycle of the frame. On the attachment-unit and general serial ports, the carrier must appear and must then stay up. On the twisted-pair port, only the link-fail state counts. The direct port loops back internally, so it never reports a loss. Internal loopback also suppresses the report. External loopback leaves the rule of the selected port in force. A loss report is only status: the block raises no request to send the frame again.

There is no data stream at the edges of the block, so all pins are plain level or pulse signals and there is no back-pressure.

Top module: `carrier_loss_mon`

## Requirements
- R1: While `rst_n` is low and after it rises, `tx_status` is all zeros and `stat_valid` is 0 until a frame ends.
- R2: On port code 2'b00 (attachment unit), if `crs_in` is never high in any cycle where `tx_active` is high, the frame reports a loss.
- R3: On port code 2'b00, if `crs_in` has been high and then goes low in a later cycle where `tx_active` is still high, the frame reports a loss. If the carrier comes up late and stays high, no loss is reported. A carrier drop in the same cycle that `tx_active` goes low is not a loss.
- R4: On port code 2'b01 (twisted pair), a loss is reported exactly when `link_fail` is high in at least one cycle of the frame. The `crs_in` input has no effect on this port.
- R5: On port code 2'b10 (general serial), the carrier rules of R2 and R3 apply unchanged.
- R6: On port code 2'b11 (direct), a loss is never reported, whatever `crs_in` and `link_fail` do.
- R7: When `lb_internal` is high at frame start, a loss is never reported. This holds even when `lb_external` is also high.
- R8: When only `lb_external` is high, the port rule applies exactly as it would with no loopback.
- R9: The loss flag is bit 7 of `tx_status`, and bits 6:0 read 0. `stat_valid` is high for exactly one cycle, the cycle after the first cycle in which `tx_active` is sampled low.
- R10: `tx_status` holds its value until the next frame begins. It reads 0 from the cycle after `tx_active` rises.
- R11: Port code and loopback bits are sampled in the first cycle of a frame. Changing them later in the frame has no effect on that frame's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | High for every cycle of a frame being sent |
| crs_in | input | 1 | Carrier sense coming back from the selected port |
| port_sel | input | 2 | 00 attachment unit, 01 twisted pair, 10 general serial, 11 direct |
| link_fail | input | 1 | Twisted-pair link is in the fail state |
| lb_internal | input | 1 | Internal loopback mode |
| lb_external | input | 1 | External loopback mode |
| tx_status | output | 8 | Transmit frame status; bit 7 is the loss-of-carrier flag |
| stat_valid | output | 1 | One-cycle pulse when `tx_status` is new |

## Verification
Two events can land in the same cycle: the carrier dropping and the end of the frame. The bench makes them coincide on every table vector by pulling `crs_in` low in the same cycle that `tx_active` falls. It judges the result against R3, which says a drop that lines up with the end of the frame is no loss. The opposite case is a drop in the last cycle where `tx_active` is still high. That one must be flagged, and a dedicated vector checks it, so an off-by-one at the frame boundary shows up in one of the two results.

// File: rtl/clm_pkg.sv
package clm_pkg;
  typedef enum logic [1:0] {
    PSEL_ATTACH  = 2'b00,
    PSEL_TWISTED = 2'b01,
    PSEL_SERIAL  = 2'b10,
    PSEL_DIRECT  = 2'b11
  } psel_e;

  typedef struct packed {
    psel_e port;
    logic  lb_int;
    logic  lb_ext;
  } mode_t;
endpackage

// File: rtl/clm_edge.sv
module clm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  output logic frame_start,
  output logic frame_stop
);
  logic tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_active;
  end

  assign frame_start = tx_active & ~tx_q;
  assign frame_stop  = ~tx_active & tx_q;
endmodule

// File: rtl/clm_track.sv
module clm_track
  import clm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  logic  tx_active,
  input  logic  crs_in,
  input  logic  link_fail,
  input  mode_t mode_in,
  output logic  seen,
  output logic  dropped,
  output logic  lf_hit,
  output mode_t mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      dropped <= 1'b0;
      lf_hit  <= 1'b0;
      mode_q  <= '0;
    end else if (frame_start) begin
      seen    <= crs_in;
      dropped <= 1'b0;
      lf_hit  <= link_fail;
      mode_q  <= mode_in;
    end else if (tx_active) begin
      seen    <= seen | crs_in;
      dropped <= dropped | (seen & ~crs_in);
      lf_hit  <= lf_hit | link_fail;
    end
  end
endmodule

// File: rtl/clm_judge.sv
module clm_judge
  import clm_pkg::*;
(
  input  mode_t mode,
  input  logic  seen,
  input  logic  dropped,
  input  logic  lf_hit,
  output logic  loss
);
  logic rule_hit;
  logic rule_on;

  always_comb begin
    unique case (mode.port)
      PSEL_ATTACH,
      PSEL_SERIAL:  rule_hit = ~seen | dropped;
      PSEL_TWISTED: rule_hit = lf_hit;
      default:      rule_hit = 1'b0;
    endcase
  end

  // external loopback keeps the port rule; internal loopback overrides
  assign rule_on = (mode.lb_ext & ~mode.lb_int) | ~mode.lb_int;
  assign loss    = rule_on & rule_hit;
endmodule

// File: rtl/clm_stat.sv
module clm_stat #(
  parameter int STAT_W   = 8,
  parameter int LOSS_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_stop,
  input  logic              loss,
  output logic [STAT_W-1:0] tx_status,
  output logic              stat_valid
);
  logic loss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loss_q     <= 1'b0;
      stat_valid <= 1'b0;
    end else if (frame_start) begin
      loss_q     <= 1'b0;
      stat_valid <= 1'b0;
    end else if (frame_stop) begin
      loss_q     <= loss;
      stat_valid <= 1'b1;
    end else begin
      stat_valid <= 1'b0;
    end
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b == LOSS_BIT) begin : g_loss
      assign tx_status[b] = loss_q;
    end else begin : g_zero
      assign tx_status[b] = 1'b0;
    end
  end
endmodule

// File: rtl/carrier_loss_mon.sv
module carrier_loss_mon
  import clm_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int LOSS_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_active,
  input  logic              crs_in,
  input  logic [1:0]        port_sel,
  input  logic              link_fail,
  input  logic              lb_internal,
  input  logic              lb_external,
  output logic [STAT_W-1:0] tx_status,
  output logic              stat_valid
);
  logic  frame_start, frame_stop;
  logic  seen, dropped, lf_hit, loss;
  mode_t mode_in, mode_q;

  assign mode_in.port   = psel_e'(port_sel);
  assign mode_in.lb_int = lb_internal;
  assign mode_in.lb_ext = lb_external;

  clm_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
    .frame_start(frame_start), .frame_stop(frame_stop)
  );

  clm_track u_track (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .tx_active(tx_active), .crs_in(crs_in), .link_fail(link_fail),
    .mode_in(mode_in), .seen(seen), .dropped(dropped),
    .lf_hit(lf_hit), .mode_q(mode_q)
  );

  clm_judge u_judge (
    .mode(mode_q), .seen(seen), .dropped(dropped),
    .lf_hit(lf_hit), .loss(loss)
  );

  clm_stat #(.STAT_W(STAT_W), .LOSS_BIT(LOSS_BIT)) u_stat (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_stop(frame_stop), .loss(loss),
    .tx_status(tx_status), .stat_valid(stat_valid)
  );
endmodule

// File: rtl/clm_checker.sv
module clm_checker #(
  parameter int STAT_W   = 8,
  parameter int LOSS_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_active,
  input logic [1:0]        port_sel,
  input logic              lb_internal,
  input logic [STAT_W-1:0] tx_status,
  input logic              stat_valid
);
  logic       tx_q;
  logic [1:0] cap_port;
  logic       cap_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q     <= 1'b0;
      cap_port <= 2'b00;
      cap_int  <= 1'b0;
    end else begin
      tx_q <= tx_active;
      if (tx_active && !tx_q) begin
        cap_port <= port_sel;
        cap_int  <= lb_internal;
      end
    end
  end

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  assert_valid_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (!$past(tx_active) && $past(tx_active, 2)));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_status) |-> (stat_valid || ($past(tx_active) && !$past(tx_active, 2))));

  assert_direct_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && cap_port == 2'b11) |-> !tx_status[LOSS_BIT]);

  assert_int_loop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && cap_int) |-> !tx_status[LOSS_BIT]);
endmodule

bind carrier_loss_mon clm_checker #(.STAT_W(STAT_W), .LOSS_BIT(LOSS_BIT)) u_clm_checker (
  .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .port_sel(port_sel),
  .lb_internal(lb_internal), .tx_status(tx_status), .stat_valid(stat_valid)
);

// File: tb/carrier_loss_mon_bench.sv
`timescale 1ns/1ps
module carrier_loss_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_active = 1'b0;
  logic       crs_in = 1'b0;
  logic [1:0] port_sel = 2'b00;
  logic       link_fail = 1'b0;
  logic       lb_internal = 1'b0;
  logic       lb_external = 1'b0;
  logic [7:0] tx_status;
  logic       stat_valid;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #2 clk = ~clk;

  carrier_loss_mon u_carrier_loss_mon (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .crs_in(crs_in),
    .port_sel(port_sel), .link_fail(link_fail), .lb_internal(lb_internal),
    .lb_external(lb_external), .tx_status(tx_status), .stat_valid(stat_valid)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] port;
    logic       lbi;
    logic       lbe;
    logic [7:0] lf;   // bit i = cycle i
    logic [7:0] crs;  // bit i = cycle i
    logic       exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 2'b00, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b0}, // R3 carrier held
    '{4'd2, 2'b00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R2 never seen
    '{4'd3, 2'b00, 1'b0, 1'b0, 8'h00, 8'h3E, 1'b0}, // R3 late rise, held
    '{4'd3, 2'b00, 1'b0, 1'b0, 8'h00, 8'h37, 1'b1}, // R3 mid drop
    '{4'd3, 2'b00, 1'b0, 1'b0, 8'h00, 8'h1F, 1'b1}, // R3 drop in last active cycle
    '{4'd5, 2'b10, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R5 never seen
    '{4'd5, 2'b10, 1'b0, 1'b0, 8'h00, 8'h1C, 1'b1}, // R5 drop
    '{4'd5, 2'b10, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b0}, // R5 held
    '{4'd4, 2'b01, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R4 no carrier, link fine
    '{4'd4, 2'b01, 1'b0, 1'b0, 8'h08, 8'h3F, 1'b1}, // R4 link fail one cycle
    '{4'd4, 2'b01, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b0}, // R4 link fine
    '{4'd6, 2'b11, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R6 no carrier
    '{4'd7, 2'b00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0}, // R7 internal loop
    '{4'd7, 2'b00, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R7 both loops
    '{4'd8, 2'b00, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1}, // R8 external loop
    '{4'd8, 2'b01, 1'b0, 1'b1, 8'h3F, 8'h00, 1'b1}, // R8 external, link fail
    '{4'd6, 2'b11, 1'b0, 1'b0, 8'h3F, 8'h00, 1'b0}  // R6 link fail ignored
  };

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got valid/status %b expected %b", tag, got, exp);
    end
  endtask

  // drives a frame of len cycles starting at a negedge; returns at the sampling negedge
  task automatic frame(input logic [1:0] p, input logic lbi, input logic lbe,
                       input logic [7:0] lf, input logic [7:0] crs, input int len);
    port_sel = p; lb_internal = lbi; lb_external = lbe;
    tx_active = 1'b1; crs_in = crs[0]; link_fail = lf[0];
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      crs_in = crs[i]; link_fail = lf[i];
    end
    @(negedge clk);
    tx_active = 1'b0; crs_in = 1'b0; link_fail = 1'b0;  // drop coincides with end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {stat_valid, tx_status}, 9'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", {stat_valid, tx_status}, 9'h000);

    for (int v = 0; v < NV; v++) begin
      frame(VECS[v].port, VECS[v].lbi, VECS[v].lbe, VECS[v].lf, VECS[v].crs, 6);
      check($sformatf("R%0d vector %0d", VECS[v].req, v),
            {stat_valid, tx_status}, {1'b1, VECS[v].exp, 7'b0});
      @(negedge clk);
    end

    // R9: pulse lasts one cycle; R10: status held while idle
    frame(2'b00, 1'b0, 1'b0, 8'h00, 8'h00, 4);
    check("R9 pulse and bit 7", {stat_valid, tx_status}, 9'h180);
    @(negedge clk);
    check("R9 pulse ends", {stat_valid, tx_status}, 9'h080);
    repeat (5) @(negedge clk);
    check("R10 held while idle", {stat_valid, tx_status}, 9'h080);

    // R10: cleared one cycle after next frame starts
    port_sel = 2'b00; tx_active = 1'b1; crs_in = 1'b1;
    @(negedge clk);
    check("R10 cleared at start", {stat_valid, tx_status}, 9'h000);
    @(negedge clk);
    tx_active = 1'b0; crs_in = 1'b0;
    @(negedge clk);
    check("R10 clean frame", {stat_valid, tx_status}, 9'h100);
    @(negedge clk);

    // R11: mode changed mid-frame has no effect
    port_sel = 2'b00; lb_internal = 1'b0; tx_active = 1'b1; crs_in = 1'b0;
    @(negedge clk);
    port_sel = 2'b11; lb_internal = 1'b1;
    repeat (3) @(negedge clk);
    tx_active = 1'b0;
    @(negedge clk);
    check("R11 mode latched at start", {stat_valid, tx_status}, 9'h180);
    @(negedge clk);

    // R11 reverse: direct at start, attach later
    port_sel = 2'b11; lb_internal = 1'b0; tx_active = 1'b1;
    @(negedge clk);
    port_sel = 2'b00;
    repeat (3) @(negedge clk);
    tx_active = 1'b0;
    @(negedge clk);
    check("R11 direct latched", {stat_valid, tx_status}, 9'h100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule